// File: doc/BRIEF.md
# Keyed Indexed Configuration Port

This block is the configuration front end of a multi-function peripheral controller. A host reaches it through two byte-wide ports on a simple I/O bus: an index port and a data port, picked by a one-bit address. The block stays locked until the host writes a two-byte key to the index port. While it is unlocked, the host writes an index to the index port and then reads or writes the addressed register through the data port. A single lock byte on the index port locks it again.

A few global registers hold the logical-device selector, a soft-reset trigger and an address-select byte for a general-purpose I/O block. Each logical device has its own register bank, and per-device indices reach the bank named by the selector. Every bank drives its activate bit, base I/O address, interrupt number, DMA channel and a row of mode bytes out as configuration outputs. The keyboard device also holds a second interrupt number, used for the mouse. The devices themselves sit outside this block.

Top module: `keyed_cfg_port`

## Requirements
- R1: While locked, an index-port write of 0x51 followed by an index-port write of 0x23 unlocks the block, and `cfg_mode` is high from the clock after the 0x23 write. Data-port accesses between the two bytes do not disturb the sequence.
- R2: While unlocked, an index-port write of 0xBB locks the block on the next clock. Any other index-port byte is stored as the current index and reads back on the index port. While locked, 0xBB has no effect.
- R3: Global index 0x07 holds the device selector (8 bits, read/write). Indices 0x30 and above reach the bank of the selected device (0 to 8). When the selector is 9 or more, per-device writes are ignored and per-device reads return 0x00.
- R4: In each bank, index 0x30 bit 0 is the activate bit and is the only bit read back. 0x60 is the high byte and 0x61 the low byte of the 16-bit base address. 0x70 holds the interrupt number and 0x74 the DMA channel. Outputs are packed per device d at `dev_base[d*16+:16]`, `dev_irq[d*8+:8]`, `dev_dma[d*8+:8]` and `dev_active[d]`.
- R5: Device 7 alone stores index 0x72 as a second interrupt number and drives it on `aux_irq`. Every other device ignores writes to 0x72 and reads it as 0x00.
- R6: A data write to global index 0x02 with bit 0 set clears every bank to zero on the next clock. It leaves the selector and index 0x03 unchanged. Index 0x02 reads 0x00, and a write with bit 0 clear does nothing.
- R7: Global index 0x03 stores bit 7, driven on `gpio_en`, and bits 1-0, driven on `gpio_sel`. The other bits read as 0.
- R8: While locked, data-port writes change nothing and reads of either port return 0xFF.
- R9: A byte other than 0x23 after 0x51 sends the key detector back to idle. A repeated 0x51 keeps it armed, so 0x51, 0x51, 0x23 unlocks.
- R10: Indices 0xF0 to 0xF4 in each bank are plain read/write bytes. Byte k of device d appears at `dev_mode[(d*5+k)*8+:8]`.
- R11: After reset everything is zero and the block is locked. Unused indices read 0x00 and ignore writes. `bus_rdata` is 0x00 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 1 | Port select: 0 index port, 1 data port |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational during `bus_rd` |
| cfg_mode | output | 1 | High while unlocked |
| dev_active | output | 9 | Activate bit per device |
| dev_base | output | 144 | Base address per device, 16 bits each |
| dev_irq | output | 72 | Interrupt number per device |
| dev_dma | output | 72 | DMA channel per device |
| aux_irq | output | 8 | Second interrupt number of device 7 |
| dev_mode | output | 360 | Five mode bytes per device |
| gpio_en | output | 1 | Access enable of the I/O block address select |
| gpio_sel | output | 2 | Port-pair select of the I/O block |

## Verification
The hardest case to reach from the ports is the key detector's edge behaviour. This covers an aborted key, a re-armed key, and a lock byte arriving while an index or selector change is still in effect. The stimulus builds these cases on purpose with doubled 0x51 bytes, wrong second bytes and data-port traffic between key bytes. A long pseudo-random stream then mixes index writes, out-of-range selectors, soft resets and lock/unlock cycles. A behavioural model of the register file is compared against every output on every clock, which catches any stray write into an unselected bank.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam logic [7:0] KEY_ARM     = 8'h51;
  localparam logic [7:0] KEY_OPEN    = 8'h23;
  localparam logic [7:0] KEY_LOCK    = 8'hBB;

  localparam logic [7:0] IX_SOFTRST  = 8'h02;
  localparam logic [7:0] IX_GPIOSEL  = 8'h03;
  localparam logic [7:0] IX_DEVSEL   = 8'h07;
  localparam logic [7:0] IX_BANK_LO  = 8'h30;
  localparam logic [7:0] IX_ACT      = 8'h30;
  localparam logic [7:0] IX_BASE_HI  = 8'h60;
  localparam logic [7:0] IX_BASE_LO  = 8'h61;
  localparam logic [7:0] IX_IRQ      = 8'h70;
  localparam logic [7:0] IX_AUX      = 8'h72;
  localparam logic [7:0] IX_DMA      = 8'h74;
  localparam logic [7:0] IX_MODE0    = 8'hF0;

  typedef enum logic [1:0] {KEY_IDLE, KEY_ARMED, KEY_OPEN_ST} key_state_e;

  // per-device indices start at the bank floor
  function automatic logic is_bank_index(input logic [7:0] ix);
    return ix >= IX_BANK_LO;
  endfunction

  // true when ix falls in the mode-byte window of n entries
  function automatic logic is_mode_index(input logic [7:0] ix, input int unsigned n);
    return (ix >= IX_MODE0) && ((32'(ix) - 32'(IX_MODE0)) < n);
  endfunction

  // keep only the fields that the I/O address select holds
  function automatic logic [7:0] gpio_view(input logic en, input logic [1:0] sel);
    return {en, 5'b00000, sel};
  endfunction
endpackage

// File: rtl/cfgp_key_unlock.sv
module cfgp_key_unlock
  import cfgp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr_i,
  input  logic [7:0] byte_i,
  output logic       cfg_on_o,
  output logic       lock_evt_o
);
  key_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (idx_wr_i) begin
      case (st_q)
        KEY_IDLE:    st_d = (byte_i == KEY_ARM) ? KEY_ARMED : KEY_IDLE;
        KEY_ARMED:   st_d = (byte_i == KEY_OPEN) ? KEY_OPEN_ST :
                            (byte_i == KEY_ARM)  ? KEY_ARMED   : KEY_IDLE;
        KEY_OPEN_ST: st_d = (byte_i == KEY_LOCK) ? KEY_IDLE : KEY_OPEN_ST;
        default:     st_d = KEY_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KEY_IDLE;
    else        st_q <= st_d;
  end

  assign cfg_on_o   = (st_q == KEY_OPEN_ST);
  assign lock_evt_o = idx_wr_i && cfg_on_o && (byte_i == KEY_LOCK);

  assert_enter_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_on_o) |-> $past(idx_wr_i && byte_i == KEY_OPEN));

  assert_enter_armed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_on_o) |-> $past(st_q == KEY_ARMED));

  assert_lock_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lock_evt_o |=> !cfg_on_o);
endmodule

// File: rtl/cfgp_dev_bank.sv
module cfgp_dev_bank
  import cfgp_pkg::*;
#(
  parameter int MODE_REGS = 5,
  parameter bit HAS_AUX   = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr_i,
  input  logic                   wr_i,
  input  logic [7:0]             idx_i,
  input  logic [7:0]             wdata_i,
  output logic [7:0]             rdata_o,
  output logic                   act_o,
  output logic [15:0]            base_o,
  output logic [7:0]             irq_o,
  output logic [7:0]             dma_o,
  output logic [7:0]             aux_o,
  output logic [MODE_REGS*8-1:0] mode_o
);
  localparam int SLOT_W = $clog2(MODE_REGS);

  logic                          act_q;
  logic [15:0]                   base_q;
  logic [7:0]                    irq_q, dma_q, aux_q;
  logic [MODE_REGS-1:0][7:0]     mode_q;
  logic [SLOT_W-1:0]             slot;
  logic                          in_mode;

  assign slot    = SLOT_W'(idx_i - IX_MODE0);
  assign in_mode = is_mode_index(idx_i, MODE_REGS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0; base_q <= '0; irq_q <= '0; dma_q <= '0; aux_q <= '0; mode_q <= '0;
    end else if (clr_i) begin
      act_q <= 1'b0; base_q <= '0; irq_q <= '0; dma_q <= '0; aux_q <= '0; mode_q <= '0;
    end else if (wr_i) begin
      case (idx_i)
        IX_ACT:     act_q        <= wdata_i[0];
        IX_BASE_HI: base_q[15:8] <= wdata_i;
        IX_BASE_LO: base_q[7:0]  <= wdata_i;
        IX_IRQ:     irq_q        <= wdata_i;
        IX_DMA:     dma_q        <= wdata_i;
        IX_AUX:     if (HAS_AUX) aux_q <= wdata_i;
        default:    if (in_mode) mode_q[slot] <= wdata_i;
      endcase
    end
  end

  always_comb begin
    case (idx_i)
      IX_ACT:     rdata_o = {7'd0, act_q};
      IX_BASE_HI: rdata_o = base_q[15:8];
      IX_BASE_LO: rdata_o = base_q[7:0];
      IX_IRQ:     rdata_o = irq_q;
      IX_DMA:     rdata_o = dma_q;
      IX_AUX:     rdata_o = HAS_AUX ? aux_q : 8'h00;
      default:    rdata_o = in_mode ? mode_q[slot] : 8'h00;
    endcase
  end

  assign act_o  = act_q;
  assign base_o = base_q;
  assign irq_o  = irq_q;
  assign dma_o  = dma_q;
  assign aux_o  = aux_q;
  assign mode_o = mode_q;

  assert_bank_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && !clr_i) |=> $stable({act_o, base_o, irq_o, dma_o, aux_o, mode_o}));

  assert_aux_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_AUX && wr_i && !clr_i && idx_i == IX_AUX) |=> (aux_o == $past(wdata_i)));
endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
  import cfgp_pkg::*;
#(
  parameter int NUM_DEV   = 9,
  parameter int MODE_REGS = 5,
  parameter int AUX_DEV   = 7
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_addr,
  input  logic                           bus_wr,
  input  logic                           bus_rd,
  input  logic [7:0]                     bus_wdata,
  output logic [7:0]                     bus_rdata,
  output logic                           cfg_mode,
  output logic [NUM_DEV-1:0]             dev_active,
  output logic [NUM_DEV*16-1:0]          dev_base,
  output logic [NUM_DEV*8-1:0]           dev_irq,
  output logic [NUM_DEV*8-1:0]           dev_dma,
  output logic [7:0]                     aux_irq,
  output logic [NUM_DEV*MODE_REGS*8-1:0] dev_mode,
  output logic                           gpio_en,
  output logic [1:0]                     gpio_sel
);
  localparam int SEL_W  = $clog2(NUM_DEV);
  localparam int MODE_W = MODE_REGS * 8;

  logic       idx_wr, dat_wr, cfg_on, lock_evt;
  logic       cfg_dat_wr, softrst_evt, bank_evt, sel_ok;
  logic [7:0] index_q, sel_q, rd_val;
  logic       gpio_en_q;
  logic [1:0] gpio_sel_q;
  logic [NUM_DEV-1:0] bank_wr;
  logic [7:0] bank_rd  [NUM_DEV];
  logic [7:0] bank_aux [NUM_DEV];

  assign idx_wr      = bus_wr && !bus_addr;
  assign dat_wr      = bus_wr &&  bus_addr;
  assign cfg_dat_wr  = cfg_on && dat_wr;
  assign softrst_evt = cfg_dat_wr && (index_q == IX_SOFTRST) && bus_wdata[0];
  assign bank_evt    = cfg_dat_wr && is_bank_index(index_q);
  assign sel_ok      = 32'(sel_q) < NUM_DEV;

  cfgp_key_unlock u_key (
    .clk(clk), .rst_n(rst_n), .idx_wr_i(idx_wr), .byte_i(bus_wdata),
    .cfg_on_o(cfg_on), .lock_evt_o(lock_evt)
  );

  // index register, device selector and I/O address select
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index_q <= '0; sel_q <= '0; gpio_en_q <= 1'b0; gpio_sel_q <= '0;
    end else begin
      if (idx_wr && cfg_on && !lock_evt) index_q <= bus_wdata;
      if (cfg_dat_wr && index_q == IX_DEVSEL) sel_q <= bus_wdata;
      if (cfg_dat_wr && index_q == IX_GPIOSEL) begin
        gpio_en_q  <= bus_wdata[7];
        gpio_sel_q <= bus_wdata[1:0];
      end
    end
  end

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_bank
    assign bank_wr[d] = bank_evt && (32'(sel_q) == d);
    cfgp_dev_bank #(.MODE_REGS(MODE_REGS), .HAS_AUX(d == AUX_DEV)) u_bank (
      .clk(clk), .rst_n(rst_n), .clr_i(softrst_evt), .wr_i(bank_wr[d]),
      .idx_i(index_q), .wdata_i(bus_wdata), .rdata_o(bank_rd[d]),
      .act_o(dev_active[d]), .base_o(dev_base[d*16 +: 16]),
      .irq_o(dev_irq[d*8 +: 8]), .dma_o(dev_dma[d*8 +: 8]),
      .aux_o(bank_aux[d]), .mode_o(dev_mode[d*MODE_W +: MODE_W])
    );
  end

  always_comb begin
    aux_irq = 8'h00;
    for (int d = 0; d < NUM_DEV; d++) aux_irq = aux_irq | bank_aux[d];
  end

  always_comb begin
    if (!cfg_on)                     rd_val = 8'hFF;
    else if (!bus_addr)              rd_val = index_q;
    else if (is_bank_index(index_q)) rd_val = sel_ok ? bank_rd[sel_q[SEL_W-1:0]] : 8'h00;
    else begin
      case (index_q)
        IX_DEVSEL:  rd_val = sel_q;
        IX_GPIOSEL: rd_val = gpio_view(gpio_en_q, gpio_sel_q);
        default:    rd_val = 8'h00;
      endcase
    end
    bus_rdata = bus_rd ? rd_val : 8'h00;
  end

  assign cfg_mode = cfg_on;
  assign gpio_en  = gpio_en_q;
  assign gpio_sel = gpio_sel_q;

  assert_bank_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_wr));

  assert_locked_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mode && dat_wr) |=> ($stable(dev_active) && $stable(dev_base) &&
                               $stable(dev_mode) && $stable(gpio_sel)));

  assert_softrst_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    softrst_evt |=> (dev_active == '0 && dev_base == '0 && dev_irq == '0 &&
                     dev_mode == '0 && aux_irq == 8'h00));
endmodule

// File: tb/sim_keyed_cfg_port.sv
`timescale 1ns/1ps
module sim_keyed_cfg_port;
  localparam int NDEV = 9;
  localparam int NMODE = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic cfg_mode, gpio_en;
  logic [1:0] gpio_sel;
  logic [NDEV-1:0] dev_active;
  logic [NDEV*16-1:0] dev_base;
  logic [NDEV*8-1:0] dev_irq, dev_dma;
  logic [7:0] aux_irq;
  logic [NDEV*NMODE*8-1:0] dev_mode;

  always #2.5 clk = ~clk;

  keyed_cfg_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_mode(cfg_mode),
    .dev_active(dev_active), .dev_base(dev_base), .dev_irq(dev_irq), .dev_dma(dev_dma),
    .aux_irq(aux_irq), .dev_mode(dev_mode), .gpio_en(gpio_en), .gpio_sel(gpio_sel)
  );

  int checks = 0, errors = 0;
  bit started = 0;

  // behavioural reference state
  int m_cfg, m_key, m_idx, m_sel, m_gen, m_gsel, m_aux;
  int m_act[NDEV], m_base[NDEV], m_irq[NDEV], m_dma[NDEV];
  int m_mode[NDEV][NMODE];

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, actual, expected, $time);
    end
  endtask

  task automatic clear_banks();
    for (int d = 0; d < NDEV; d++) begin
      m_act[d] = 0; m_base[d] = 0; m_irq[d] = 0; m_dma[d] = 0;
      for (int k = 0; k < NMODE; k++) m_mode[d][k] = 0;
    end
    m_aux = 0;
  endtask

  function automatic int model_read(input bit port);
    if (m_cfg == 0) return 'hFF;
    if (!port) return m_idx;
    if (m_idx >= 'h30) begin
      if (m_sel >= NDEV) return 0;
      if (m_idx == 'h30) return m_act[m_sel];
      if (m_idx == 'h60) return m_base[m_sel] >> 8;
      if (m_idx == 'h61) return m_base[m_sel] & 'hFF;
      if (m_idx == 'h70) return m_irq[m_sel];
      if (m_idx == 'h74) return m_dma[m_sel];
      if (m_idx == 'h72) return (m_sel == 7) ? m_aux : 0;
      if (m_idx >= 'hF0 && m_idx < 'hF0 + NMODE) return m_mode[m_sel][m_idx - 'hF0];
      return 0;
    end
    if (m_idx == 'h07) return m_sel;
    if (m_idx == 'h03) return (m_gen << 7) | m_gsel;
    return 0;
  endfunction

  task automatic model_write(input bit port, input int d);
    if (!port) begin
      if (m_cfg != 0) begin
        if (d == 'hBB) begin m_cfg = 0; m_key = 0; end
        else m_idx = d;
      end else if (m_key == 1 && d == 'h23) begin
        m_cfg = 1; m_key = 0;
      end else m_key = (d == 'h51) ? 1 : 0;
    end else if (m_cfg != 0) begin
      if (m_idx == 'h07) m_sel = d;
      else if (m_idx == 'h03) begin m_gen = (d >> 7) & 1; m_gsel = d & 3; end
      else if (m_idx == 'h02) begin if ((d & 1) != 0) clear_banks(); end
      else if (m_idx >= 'h30 && m_sel < NDEV) begin
        if (m_idx == 'h30) m_act[m_sel] = d & 1;
        else if (m_idx == 'h60) m_base[m_sel] = (d << 8) | (m_base[m_sel] & 'hFF);
        else if (m_idx == 'h61) m_base[m_sel] = (m_base[m_sel] & 'hFF00) | d;
        else if (m_idx == 'h70) m_irq[m_sel] = d;
        else if (m_idx == 'h74) m_dma[m_sel] = d;
        else if (m_idx == 'h72) begin if (m_sel == 7) m_aux = d; end
        else if (m_idx >= 'hF0 && m_idx < 'hF0 + NMODE) m_mode[m_sel][m_idx - 'hF0] = d;
      end
    end
  endtask

  // one bus access; read data checked mid-cycle, model advanced after the edge
  task automatic bus_op(input bit port, input bit wr, input bit rd, input int d);
    @(negedge clk);
    bus_addr = port; bus_wr = wr; bus_rd = rd; bus_wdata = 8'(d);
    if (rd) begin
      #1;
      if (m_cfg == 0) check("R8 locked read", bus_rdata, model_read(port));
      else if (!port) check("R2 index readback", bus_rdata, model_read(port));
      else check("R3/R4/R10 data read", bus_rdata, model_read(port));
    end
    @(posedge clk);
    #1;
    if (wr) model_write(port, d & 'hFF);
    bus_wr = 1'b0; bus_rd = 1'b0;
    #0.5;
    check("R11 idle rdata", bus_rdata, 0);
  endtask

  task automatic idx_w(input int d); bus_op(1'b0, 1'b1, 1'b0, d); endtask
  task automatic dat_w(input int d); bus_op(1'b1, 1'b1, 1'b0, d); endtask
  task automatic dat_r();            bus_op(1'b1, 1'b0, 1'b1, 0);  endtask
  task automatic idx_r();            bus_op(1'b0, 1'b0, 1'b1, 0);  endtask
  task automatic unlock();           idx_w('h51); idx_w('h23);     endtask

  // every clock: all configuration outputs against the model
  always @(negedge clk) begin
    if (started) begin
      check("R1/R2 cfg_mode", cfg_mode, m_cfg);
      for (int d = 0; d < NDEV; d++) begin
        check("R4 active", dev_active[d], m_act[d]);
        check("R4 base", dev_base[d*16 +: 16], m_base[d]);
        check("R4 irq", dev_irq[d*8 +: 8], m_irq[d]);
        check("R4 dma", dev_dma[d*8 +: 8], m_dma[d]);
        for (int k = 0; k < NMODE; k++)
          check("R10 mode byte", dev_mode[(d*NMODE+k)*8 +: 8], m_mode[d][k]);
      end
      check("R5 aux irq", aux_irq, m_aux);
      check("R7 gpio_en", gpio_en, m_gen);
      check("R7 gpio_sel", gpio_sel, m_gsel);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic int pick_ix(input int n);
    case (n % 16)
      0: return 'h07;  1: return 'h30;  2: return 'h60;  3: return 'h61;
      4: return 'h70;  5: return 'h72;  6: return 'h74;  7: return 'hF0;
      8: return 'hF1;  9: return 'hF2; 10: return 'hF3; 11: return 'hF4;
      12: return 'h03; 13: return 'h02; 14: return 'h45;
      default: return 'hF5;
    endcase
  endfunction

  logic [15:0] lfsr = 16'hACE1;

  initial begin
    m_cfg = 0; m_key = 0; m_idx = 0; m_sel = 0; m_gen = 0; m_gsel = 0;
    clear_banks();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    started = 1;
    @(negedge clk);
    // R11 reset state
    check("R11 reset cfg_mode", cfg_mode, 0);
    check("R11 reset base", int'(dev_base == '0), 1);

    // R8 locked accesses
    dat_w('h5A); dat_r(); idx_r();
    idx_w('h07); dat_w('h03); dat_r();
    idx_w('hBB);
    check("R2 lock byte while locked", cfg_mode, 0);

    // R9 aborted and re-armed keys
    idx_w('h51); idx_w('h24); idx_w('h23);
    check("R9 aborted key stays locked", cfg_mode, 0);
    idx_w('h51); idx_w('h51); idx_w('h23);
    check("R9 re-armed key unlocks", cfg_mode, 1);
    idx_w('hBB);
    check("R2 exit", cfg_mode, 0);
    idx_w('h51); dat_w('h11); dat_r(); idx_w('h23);
    check("R1 key with data traffic between", cfg_mode, 1);
    idx_r();

    // R3 R4 R5 R10 program every device
    for (int d = 0; d < NDEV; d++) begin
      idx_w('h07); dat_w(d);
      idx_w('h30); dat_w((d % 2 == 1) ? 'h03 : 'hFE);
      idx_w('h60); dat_w('h10 + d);
      idx_w('h61); dat_w(d * 16 + 8);
      idx_w('h70); dat_w(d + 3);
      idx_w('h74); dat_w(d & 3);
      idx_w('h72); dat_w('h0C);
      for (int k = 0; k < NMODE; k++) begin idx_w('hF0 + k); dat_w((d*NMODE + k) * 7); end
    end
    for (int d = 0; d < NDEV; d++) begin
      idx_w('h07); dat_w(d); dat_r();
      for (int j = 0; j < 12; j++) begin idx_w(pick_ix(j)); dat_r(); end
    end
    check("R5 aux output of device 7", aux_irq, 'h0C);

    // R3 out-of-range selector
    idx_w('h07); dat_w(9);
    idx_w('h30); dat_w('h00); dat_r();
    idx_w('hF2); dat_w('h77); dat_r();

    // R11 unused indices
    idx_w('h10); dat_w('h99); dat_r();
    idx_w('h07); dat_w(2);
    idx_w('h31); dat_w('h99); dat_r();

    // R7 address select
    idx_w('h03); dat_w('hFF); dat_r();
    check("R7 gpio_sel after 0xFF", gpio_sel, 3);
    dat_w('h81); dat_r();

    // R6 soft reset
    idx_w('h02); dat_w('h00); dat_r();
    dat_w('h01); dat_r();
    check("R6 banks cleared", int'(dev_base == '0 && dev_mode == '0), 1);
    idx_w('h07); dat_r();
    idx_w('h03); dat_r();

    // R8 after relock
    idx_w('hBB);
    dat_w('h44); dat_r(); idx_r();
    unlock();

    // mixed pseudo-random traffic
    for (int i = 0; i < 1500; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[2:0])
        3'd0, 3'd1, 3'd2: idx_w(pick_ix(int'(lfsr[7:4])));
        3'd3: dat_w(int'(lfsr[15:8]));
        3'd4: begin idx_w('h07); dat_w(int'(lfsr[11:8]) % 11); end
        3'd5: dat_r();
        3'd6: idx_r();
        default: begin
          if (lfsr[10:8] == 3'd0) idx_w('hBB);
          else if (m_cfg == 0) begin
            idx_w('h51);
            idx_w(lfsr[9] ? 'h23 : int'(lfsr[15:8]));
          end else idx_w(int'(lfsr[15:8]));
        end
      endcase
      if (m_cfg == 0 && lfsr[12:11] == 2'b11) unlock();
    end

    repeat (2) @(negedge clk);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule